// File: doc/BRIEF.md
# Unpacked BCD Adjust Unit

This unit corrects a 16-bit accumulator, held as a high byte and a low byte, after arithmetic on unpacked decimal digits (one digit per byte). Four operations are selected by a 2-bit code. Two of them fix a digit left by a byte add or subtract, carrying or borrowing into the high byte. The other two split a binary low byte into a quotient and a remainder by a base, or fold the two bytes into one binary byte with that base. The base is an 8-bit input, and a base of zero selects the default of 10.

The two digit fixes are combinational and their result is registered one cycle after `start`. The two base operations run on a small sequencer that steps an 8-iteration restoring divider or an 8-iteration shift-add multiplier. A mode input chooses whether a carry (or borrow) that leaves the low byte during the digit fix on an invalid operand also reaches the high byte. The sequencer has two states. It stays in IDLE while no start is seen or while a digit fix is taken. It goes from IDLE to RUN on a start with a base operation, stays in RUN while the step count is below 7, and returns from RUN to IDLE on the last step, when it writes the result and pulses `done`.

Top module: `bcd_adjust_unit`

## Requirements
- R1: Operation code 0 (add fix): if the low nibble of the low byte exceeds 9 or `af_in` is 1, the low byte gets 6 added, the high byte gets 1 added, and AF and CF are set. Otherwise AF and CF are cleared and the high byte is kept. In both cases bits 7:4 of the low byte are cleared in the result.
- R2: Operation code 1 (subtract fix): under the same condition as R1, the low byte loses 6, the high byte loses 1, and AF and CF are set. Otherwise both are cleared. Bits 7:4 of the low byte are cleared in the result.
- R3: With `carry_prop` at 1, a fix that carries out of the low byte (low byte above F9h on add) adds a further 1 to the high byte, and a fix that borrows out of it (low byte below 06h on subtract) takes a further 1. With `carry_prop` at 0 no such extra step occurs.
- R4: Operation code 2 (split): the high byte becomes the low byte divided by the base and the low byte becomes the remainder. The input high byte has no effect.
- R5: Operation code 3 (fold): the low byte becomes high byte times base plus low byte, kept to 8 bits, and the high byte becomes 0.
- R6: Codes 2 and 3 set SF to bit 7 of the new low byte, ZF to 1 when it is zero, and PF to 1 when it has an even number of set bits, and they keep AF and CF. Codes 0 and 1 keep SF, ZF and PF.
- R7: A `base_in` of 0 acts as a base of 10.
- R8: For codes 0 and 1, `done` is high in the cycle after `start` is taken. For codes 2 and 3, `busy` is high and `done` is low for 8 cycles, and `done` rises 8 cycles after `start` is taken.
- R9: `done` lasts one cycle. A `start` seen while `busy` is high is dropped and changes neither the running result nor anything after it.
- R10: After reset the accumulator output and all flags are 0, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| op_in | input | 2 | 0 add fix, 1 subtract fix, 2 split, 3 fold |
| carry_prop | input | 1 | 1 lets a carry or borrow out of the low byte reach the high byte |
| acc_in | input | 16 | Accumulator, high byte in bits 15:8 |
| base_in | input | 8 | Base for split and fold, 0 means 10 |
| af_in | input | 1 | Incoming adjust flag |
| cf_in | input | 1 | Incoming carry flag (not used by these operations) |
| busy | output | 1 | Sequencer in RUN |
| done | output | 1 | One-cycle result pulse |
| acc_out | output | 16 | Result accumulator |
| af_out | output | 1 | Adjust flag |
| cf_out | output | 1 | Carry flag |
| sf_out | output | 1 | Sign flag |
| zf_out | output | 1 | Zero flag |
| pf_out | output | 1 | Parity flag, 1 for even |

## Verification
A digit fix is due one clock edge after the start edge, so the bench drives `start` on a falling edge and reads `done`, the accumulator and the flags on the next falling edge. A split or fold is due eight edges after the start edge: the bench confirms `done` is low at each of the eight falling edges in between and reads the result at the eighth. The dropped-start test keeps watching for ten cycles after the pulse, so a start that was queued would show up as a second pulse or a changed result.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
    typedef enum logic [1:0] {
        OP_ADD_FIX = 2'd0,
        OP_SUB_FIX = 2'd1,
        OP_SPLIT   = 2'd2,
        OP_FOLD    = 2'd3
    } adj_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } adj_state_e;
endpackage

// File: rtl/bcd_digit_fix.sv
module bcd_digit_fix #(
    parameter int BYTE_W = 8
) (
    input  logic              subtract,
    input  logic              carry_prop,
    input  logic              af_in,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out,
    output logic              fixed
);
    localparam int NIB = 4;
    localparam logic [BYTE_W-1:0] TOP_OK = BYTE_W'((1 << BYTE_W) - 7);
    localparam logic [BYTE_W-1:0] SIX    = BYTE_W'(6);

    logic [NIB-1:0]    nib_fix;
    logic              spill;
    logic [BYTE_W-1:0] hi_step;

    always_comb begin
        fixed   = (lo_in[NIB-1:0] > NIB'(9)) || af_in;
        nib_fix = subtract ? (lo_in[NIB-1:0] - NIB'(6)) : (lo_in[NIB-1:0] + NIB'(6));
        spill   = subtract ? (lo_in < SIX) : (lo_in > TOP_OK);
        hi_step = BYTE_W'(fixed) + BYTE_W'(fixed && carry_prop && spill);
        hi_out  = subtract ? (hi_in - hi_step) : (hi_in + hi_step);
        lo_out  = {{(BYTE_W-NIB){1'b0}}, fixed ? nib_fix : lo_in[NIB-1:0]};
    end
endmodule

// File: rtl/bcd_div_step.sv
module bcd_div_step #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] rem_in,
    input  logic [BYTE_W-1:0] quo_in,
    input  logic [BYTE_W-1:0] divisor,
    output logic [BYTE_W-1:0] rem_out,
    output logic [BYTE_W-1:0] quo_out
);
    logic [BYTE_W:0] trial;
    logic [BYTE_W:0] diff;
    logic            fits;

    always_comb begin
        trial   = {rem_in, quo_in[BYTE_W-1]};
        diff    = trial - {1'b0, divisor};
        fits    = !diff[BYTE_W];
        rem_out = fits ? diff[BYTE_W-1:0] : trial[BYTE_W-1:0];
        quo_out = {quo_in[BYTE_W-2:0], fits};
    end
endmodule

// File: rtl/bcd_mul_step.sv
module bcd_mul_step #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] sum_in,
    input  logic [BYTE_W-1:0] mcand_in,
    input  logic [BYTE_W-1:0] mplier_in,
    output logic [BYTE_W-1:0] sum_out,
    output logic [BYTE_W-1:0] mcand_out,
    output logic [BYTE_W-1:0] mplier_out
);
    always_comb begin
        sum_out    = mplier_in[0] ? (sum_in + mcand_in) : sum_in;
        mcand_out  = {mcand_in[BYTE_W-2:0], 1'b0};
        mplier_out = {1'b0, mplier_in[BYTE_W-1:1]};
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit #(
    parameter int BYTE_W       = 8,
    parameter int DEFAULT_BASE = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          op_in,
    input  logic                carry_prop,
    input  logic [2*BYTE_W-1:0] acc_in,
    input  logic [BYTE_W-1:0]   base_in,
    input  logic                af_in,
    input  logic                cf_in,
    output logic                busy,
    output logic                done,
    output logic [2*BYTE_W-1:0] acc_out,
    output logic                af_out,
    output logic                cf_out,
    output logic                sf_out,
    output logic                zf_out,
    output logic                pf_out
);
    import bcd_adj_pkg::*;

    localparam int STEPS = BYTE_W;
    localparam int CNT_W = $clog2(STEPS);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);

    adj_state_e        state, state_nx;
    adj_op_e           op_sel, op_q;
    logic [CNT_W-1:0]  step_cnt;
    logic [BYTE_W-1:0] reg_a, reg_b, reg_c;
    logic [BYTE_W-1:0] base_eff;
    logic [BYTE_W-1:0] lo_in, hi_in;
    logic              take;
    logic              last;

    logic [BYTE_W-1:0] fix_lo, fix_hi;
    logic              fix_hit;
    logic [BYTE_W-1:0] div_rem, div_quo;
    logic [BYTE_W-1:0] mul_sum, mul_mcand, mul_mplier;
    logic [BYTE_W-1:0] res_lo;

    assign lo_in    = acc_in[BYTE_W-1:0];
    assign hi_in    = acc_in[2*BYTE_W-1:BYTE_W];
    assign op_sel   = adj_op_e'(op_in);
    assign base_eff = (base_in == '0) ? BYTE_W'(DEFAULT_BASE) : base_in;
    assign take     = start && (state == ST_IDLE);
    assign last     = (state == ST_RUN) && (step_cnt == LAST_STEP);
    assign res_lo   = (op_q == OP_SPLIT) ? div_rem : mul_sum;

    bcd_digit_fix #(.BYTE_W(BYTE_W)) u_fix (
        .subtract  (op_sel == OP_SUB_FIX),
        .carry_prop(carry_prop),
        .af_in     (af_in),
        .lo_in     (lo_in),
        .hi_in     (hi_in),
        .lo_out    (fix_lo),
        .hi_out    (fix_hi),
        .fixed     (fix_hit)
    );

    bcd_div_step #(.BYTE_W(BYTE_W)) u_div (
        .rem_in (reg_b),
        .quo_in (reg_a),
        .divisor(reg_c),
        .rem_out(div_rem),
        .quo_out(div_quo)
    );

    bcd_mul_step #(.BYTE_W(BYTE_W)) u_mul (
        .sum_in    (reg_a),
        .mcand_in  (reg_b),
        .mplier_in (reg_c),
        .sum_out   (mul_sum),
        .mcand_out (mul_mcand),
        .mplier_out(mul_mplier)
    );

    // next state and status outputs
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take && (op_sel == OP_SPLIT || op_sel == OP_FOLD)) state_nx = ST_RUN;
            ST_RUN:  if (last) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
        busy = (state == ST_RUN);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_ADD_FIX;
            step_cnt <= '0;
            reg_a    <= '0;
            reg_b    <= '0;
            reg_c    <= '0;
            acc_out  <= '0;
            done     <= 1'b0;
            af_out   <= 1'b0;
            cf_out   <= 1'b0;
            sf_out   <= 1'b0;
            zf_out   <= 1'b0;
            pf_out   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        op_q     <= op_sel;
                        step_cnt <= '0;
                        reg_a    <= lo_in;
                        reg_b    <= (op_sel == OP_FOLD) ? hi_in : '0;
                        reg_c    <= base_eff;
                        if (op_sel == OP_ADD_FIX || op_sel == OP_SUB_FIX) begin
                            acc_out <= {fix_hi, fix_lo};
                            af_out  <= fix_hit;
                            cf_out  <= fix_hit;
                            done    <= 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    step_cnt <= step_cnt + 1'b1;
                    if (op_q == OP_SPLIT) begin
                        reg_a <= div_quo;
                        reg_b <= div_rem;
                    end else begin
                        reg_a <= mul_sum;
                        reg_b <= mul_mcand;
                        reg_c <= mul_mplier;
                    end
                    if (last) begin
                        acc_out <= (op_q == OP_SPLIT) ? {div_quo, div_rem} : {{BYTE_W{1'b0}}, mul_sum};
                        sf_out  <= res_lo[BYTE_W-1];
                        zf_out  <= (res_lo == '0);
                        pf_out  <= ~^res_lo;
                        done    <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    logic unused_cf;
    assign unused_cf = cf_in;
endmodule

// File: rtl/bcd_adjust_checker.sv
module bcd_adjust_checker #(
    parameter int BYTE_W       = 8,
    parameter int DEFAULT_BASE = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [1:0]          op_in,
    input logic [BYTE_W-1:0]   base_in,
    input logic                busy,
    input logic                done,
    input logic [2*BYTE_W-1:0] acc_out,
    input logic                af_out,
    input logic                cf_out,
    input logic                zf_out
);
    logic [1:0]        chk_op;
    logic [BYTE_W-1:0] chk_base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_op   <= 2'd0;
            chk_base <= BYTE_W'(DEFAULT_BASE);
        end else if (start && !busy) begin
            chk_op   <= op_in;
            chk_base <= (base_in == '0) ? BYTE_W'(DEFAULT_BASE) : base_in;
        end
    end

    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    fix_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_in < 2'd2) |=> done);
    // R8
    run_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op_in >= 2'd2) |=> (busy && !done));
    // R9
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(acc_out) || done));
    // R1
    fix_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_op < 2'd2) |-> (acc_out[BYTE_W-1:4] == '0 && af_out == cf_out));
    // R4
    rem_below_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_op == 2'd2) |-> (acc_out[BYTE_W-1:0] < chk_base));
    // R5
    fold_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_op == 2'd3) |-> (acc_out[2*BYTE_W-1:BYTE_W] == '0));
    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_op >= 2'd2) |-> (zf_out == (acc_out[BYTE_W-1:0] == '0)));
endmodule

bind bcd_adjust_unit bcd_adjust_checker #(
    .BYTE_W(BYTE_W),
    .DEFAULT_BASE(DEFAULT_BASE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_in  (op_in),
    .base_in(base_in),
    .busy   (busy),
    .done   (done),
    .acc_out(acc_out),
    .af_out (af_out),
    .cf_out (cf_out),
    .zf_out (zf_out)
);

// File: tb/tb_bcd_adjust_unit.sv
module tb_bcd_adjust_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_in = 2'd0;
    logic        carry_prop = 1'b0;
    logic [15:0] acc_in = 16'h0;
    logic [7:0]  base_in = 8'd10;
    logic        af_in = 1'b0;
    logic        cf_in = 1'b0;
    logic        busy, done, af_out, cf_out, sf_out, zf_out, pf_out;
    logic [15:0] acc_out;

    int n_chk = 0;
    int n_bad = 0;
    logic e_af = 0, e_cf = 0, e_sf = 0, e_zf = 0, e_pf = 0;

    always #4 clk = ~clk;

    bcd_adjust_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in),
        .carry_prop(carry_prop), .acc_in(acc_in), .base_in(base_in),
        .af_in(af_in), .cf_in(cf_in), .busy(busy), .done(done),
        .acc_out(acc_out), .af_out(af_out), .cf_out(cf_out),
        .sf_out(sf_out), .zf_out(zf_out), .pf_out(pf_out)
    );

    // op, prop, af, cf, acc, base, expected acc, expected af, expected cf
    localparam int NV = 20;
    localparam logic [46:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 16'h0005, 8'd10, 16'h0005, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0, 16'h000C, 8'd10, 16'h0102, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b1, 1'b0, 16'h0312, 8'd10, 16'h0408, 1'b1, 1'b1},
        {2'd0, 1'b0, 1'b0, 1'b0, 16'h05FB, 8'd10, 16'h0601, 1'b1, 1'b1},
        {2'd0, 1'b1, 1'b0, 1'b0, 16'h05FB, 8'd10, 16'h0701, 1'b1, 1'b1},
        {2'd0, 1'b1, 1'b0, 1'b1, 16'h00FA, 8'd10, 16'h0200, 1'b1, 1'b1},
        {2'd1, 1'b0, 1'b0, 1'b0, 16'h020F, 8'd10, 16'h0109, 1'b1, 1'b1},
        {2'd1, 1'b0, 1'b0, 1'b1, 16'h0237, 8'd10, 16'h0207, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b1, 1'b0, 16'h0403, 8'd10, 16'h030D, 1'b1, 1'b1},
        {2'd1, 1'b1, 1'b1, 1'b0, 16'h0403, 8'd10, 16'h020D, 1'b1, 1'b1},
        {2'd2, 1'b0, 1'b0, 1'b0, 16'h0051, 8'd10, 16'h0801, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 1'b0, 16'hFF3F, 8'd0,  16'h0603, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 1'b0, 16'h00FF, 8'd16, 16'h0F0F, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0, 16'h0007, 8'd10, 16'h0007, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 1'b0, 16'h0014, 8'd10, 16'h0200, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 1'b0, 16'h00C8, 8'd7,  16'h1C04, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 16'h0907, 8'd10, 16'h0061, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 16'h1905, 8'd0,  16'h00FF, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 16'h1A00, 8'd10, 16'h0004, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 16'h0203, 8'd16, 16'h0023, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic prop, input logic af, input logic [7:0] lo, input logic [7:0] base);
        if (base == 8'd0) return "R7";
        if (op == 2'd0 && (prop || lo > 8'hF9)) return "R3";
        if (op == 2'd1 && (prop || (af && lo < 8'h06))) return "R3";
        if (op == 2'd0) return "R1";
        if (op == 2'd1) return "R2";
        if (op == 2'd2) return "R4";
        return "R5";
    endfunction

    task automatic run_op(input logic [1:0] op, input logic prop, input logic af, input logic cf,
                          input logic [15:0] acc, input logic [7:0] base,
                          input logic [15:0] exp_acc, input logic eaf, input logic ecf);
        string t;
        int early;
        t = tag_of(op, prop, af, acc[7:0], base);
        @(negedge clk);
        op_in = op; carry_prop = prop; af_in = af; cf_in = cf; acc_in = acc; base_in = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (op >= 2'd2) begin
            early = 0;
            for (int k = 0; k < 8; k++) begin
                if (done || !busy) early++;
                @(negedge clk);
            end
            check("R8", "no early done over 8 cycles", early, 0);
        end
        check("R8", "done at due cycle", done, 1'b1);
        if (op < 2'd2) begin
            e_af = eaf; e_cf = ecf;
        end else begin
            e_sf = exp_acc[7]; e_zf = (exp_acc[7:0] == 8'h00); e_pf = ~^exp_acc[7:0];
        end
        check(t, "accumulator", acc_out, exp_acc);
        check(t, "af", af_out, e_af);
        check(t, "cf", cf_out, e_cf);
        check("R6", "sf/zf/pf", {sf_out, zf_out, pf_out}, {e_sf, e_zf, e_pf});
        @(negedge clk);
        check("R9", "done one cycle", done, 1'b0);
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int extra;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", "reset outputs", {acc_out, af_out, cf_out, sf_out, zf_out, pf_out, busy, done}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][46:45], VEC[i][44], VEC[i][43], VEC[i][42], VEC[i][41:26],
                   VEC[i][25:18], VEC[i][17:2], VEC[i][1], VEC[i][0]);
        end

        // R9: start during a split is dropped
        @(negedge clk);
        op_in = 2'd2; acc_in = 16'h0051; base_in = 8'd10; start = 1'b1;
        @(negedge clk);
        op_in = 2'd3; acc_in = 16'h1905; start = 1'b1;
        check("R9", "busy after start", busy, 1'b1);
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R9", "first op finishes", done, 1'b1);
        check("R9", "first op result kept", acc_out, 16'h0801);
        extra = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done || busy) extra++;
        end
        check("R9", "no queued op", extra, 0);
        check("R9", "result unchanged", acc_out, 16'h0801);

        // R4: input high byte has no effect on a split
        run_op(2'd2, 1'b0, 1'b0, 1'b0, 16'hA963, 8'd10, 16'h0909, 1'b0, 1'b0);

        // R10: reset during a run clears everything
        @(negedge clk);
        op_in = 2'd3; acc_in = 16'h0907; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "reset mid-run", {acc_out, af_out, cf_out, sf_out, zf_out, pf_out, busy, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule